// File: doc/BRIEF.md
# Two-Way Set-Associative Translation Buffer

This block caches virtual-to-physical page translations for a 32-bit virtual address space with 4 KB pages. It holds 128 translations as two ways of 64 sets. A lookup gives the virtual address, the current process identifier and whether the access comes from user mode. In the same cycle the block reports a hit or a miss, the way that hit, the physical page number, four page attribute bits and a denial flag. A denial is raised when user code touches a page marked for the system only. Address bit 31 splits the space into a system half (1) and a user half (0). System pages are shared by every process, so their process identifier is not compared.

Translations enter through a refill port that carries a fetched page table entry together with the virtual address and process identifier it belongs to. A refill that matches a translation already held rewrites that entry in place. Otherwise it goes to an empty way of the indexed set, or, when both ways are full, to the way that was filled first. One bit per set tracks which way that is. A single-cycle flush input empties the whole buffer. Walking the page tables and reporting faults belong to the surrounding logic.

Top module: `tlb2w`

## Requirements
- R1: After reset, and in the cycle after `flush` is high, every lookup misses. `flush` takes priority over a refill presented in the same cycle, and that refill is discarded.
- R2: Address bits 11:0 are not used. Bits 17:12 select the set. Bits 31:18 form the tag. A hit needs a valid entry in the selected set whose tag is equal.
- R3: When bit 31 of the lookup address is 0, a hit also needs the stored process identifier to equal `lk_pid`. When bit 31 is 1, the identifier is not compared.
- R4: On a hit, `lk_ppn` and `lk_attr` return the matching entry and `lk_way` names the way (0 or 1). The attribute bits are [3] cacheable, [2] system-only, [1] clean, [0] page-not-present. With no hit, `lk_ppn`, `lk_attr` and `lk_way` are zero.
- R5: `lk_miss` equals `lk_req` and not a hit. `lk_hit` and `lk_miss` are both 0 while `lk_req` is 0.
- R6: `lk_deny` is 1 exactly when there is a hit, `lk_user` is 1, and the hit entry has attribute bit [2] set.
- R7: A refill that matches no entry, into a set with at least one empty way, fills the lowest-numbered empty way (way 0 if both are empty). The set's first-come bit then points at the other way.
- R8: A refill that matches no entry, into a set with both ways valid, replaces the way the first-come bit points at and inverts the bit. Repeated new refills to a full set therefore alternate between the ways in arrival order.
- R9: A refill whose tag and identifier (the identifier only for user-space addresses) match a valid entry of its set overwrites that entry and leaves the first-come bit unchanged. At most one way ever hits for a lookup.
- R10: A refill takes effect from the next cycle on. A lookup in the same cycle as a refill sees the contents from before the refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_pid | input | 8 | Current process identifier |
| lk_user | input | 1 | Access made from user mode |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Lookup requested and not found |
| lk_way | output | 1 | Way that hit |
| lk_ppn | output | 20 | Physical page number of the hit |
| lk_attr | output | 4 | Attribute bits of the hit |
| lk_deny | output | 1 | User access to a system-only page |
| rf_req | input | 1 | Refill request |
| rf_vaddr | input | 32 | Virtual address of the refilled page |
| rf_pid | input | 8 | Process identifier of the refilled page |
| rf_ppn | input | 20 | Physical page number to store |
| rf_attr | input | 4 | Attribute bits to store |

## Verification
The hardest cases to reach from the ports are the replacement choices that depend on the per-set first-come bit. These are a new refill into a full set, and a refill that must overwrite a matching entry rather than evict the older one. The bench reaches them with directed fills to one set (empty, half full, full, then repeated new tags and one repeated tag). It then runs a long random stream confined to three sets, a few tags and two identifiers, so that collisions, duplicate refills and flushes that race refills all occur often. A behavioural model in the bench predicts every output on every cycle.

// File: rtl/tlb2w_pkg.sv
package tlb2w_pkg;

   // Attribute bits of one cached translation, MSB first.
   typedef struct packed {
      logic cacheable;
      logic sys_only;
      logic clean;
      logic absent;
   } pte_attr_t;

   localparam int ATTR_W = $bits(pte_attr_t);

endpackage

// File: rtl/tlb2w_way.sv
module tlb2w_way
   import tlb2w_pkg::*;
#(
   parameter  int SETS  = 64,
   parameter  int TAG_W = 14,
   parameter  int PID_W = 8,
   parameter  int PPN_W = 20,
   localparam int IDX_W = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   // lookup side
   input  logic [IDX_W-1:0] lk_idx,
   input  logic [TAG_W-1:0] lk_tag,
   input  logic [PID_W-1:0] lk_pid,
   input  logic             lk_sys,
   output logic             lk_match,
   output logic [PPN_W-1:0] lk_ppn,
   output pte_attr_t        lk_attr,
   // refill side: probe and write share one index
   input  logic [IDX_W-1:0] rf_idx,
   input  logic [TAG_W-1:0] rf_tag,
   input  logic [PID_W-1:0] rf_pid,
   input  logic             rf_sys,
   input  logic [PPN_W-1:0] rf_ppn,
   input  pte_attr_t        rf_attr,
   input  logic             wr_en,
   output logic             pr_match,
   output logic             pr_valid
);

   logic [SETS-1:0]  valid_q;
   logic [TAG_W-1:0] tag_q  [SETS];
   logic [PID_W-1:0] pid_q  [SETS];
   logic [PPN_W-1:0] ppn_q  [SETS];
   pte_attr_t        attr_q [SETS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (flush) begin
         valid_q <= '0;
      end else if (wr_en) begin
         valid_q[rf_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en && !flush) begin
         tag_q[rf_idx]  <= rf_tag;
         pid_q[rf_idx]  <= rf_pid;
         ppn_q[rf_idx]  <= rf_ppn;
         attr_q[rf_idx] <= rf_attr;
      end
   end

   always_comb begin
      lk_match = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag)
                 && (lk_sys || (pid_q[lk_idx] == lk_pid));
      lk_ppn   = ppn_q[lk_idx];
      lk_attr  = attr_q[lk_idx];
      pr_valid = valid_q[rf_idx];
      pr_match = pr_valid && (tag_q[rf_idx] == rf_tag)
                 && (rf_sys || (pid_q[rf_idx] == rf_pid));
   end

   // R1: a flush leaves no valid entry behind
   assert_flush_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (valid_q == '0));

   // R10: a write is visible as a valid entry on the next cycle
   assert_write_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !flush) |=> valid_q[$past(rf_idx)]);

endmodule

// File: rtl/tlb2w_repl.sv
module tlb2w_repl #(
   parameter  int SETS  = 64,
   localparam int IDX_W = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             rf_req,
   input  logic [IDX_W-1:0] rf_idx,
   input  logic [1:0]       pr_match,
   input  logic [1:0]       pr_valid,
   output logic             victim
);

   // per set: the way that was filled first and goes next
   logic [SETS-1:0] first_q;
   logic            overwrite;

   always_comb begin
      overwrite = |pr_match;
      if (pr_match[1])       victim = 1'b1;
      else if (pr_match[0])  victim = 1'b0;
      else if (!pr_valid[0]) victim = 1'b0;
      else if (!pr_valid[1]) victim = 1'b1;
      else                   victim = first_q[rf_idx];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         first_q <= '0;
      end else if (flush) begin
         first_q <= '0;
      end else if (rf_req && !overwrite) begin
         first_q[rf_idx] <= ~victim;
      end
   end

   // R8: a new fill into a full set inverts the first-come bit
   assert_full_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_req && !flush && pr_valid == 2'b11 && pr_match == 2'b00)
      |=> first_q[$past(rf_idx)] != $past(first_q[rf_idx]));

   // R9: rewriting a matching entry keeps the first-come bit
   assert_overwrite_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_req && !flush && pr_match != 2'b00)
      |=> first_q[$past(rf_idx)] == $past(first_q[rf_idx]));

   // R7: a fill into a set with an empty way targets an empty way
   assert_fill_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_req && pr_valid != 2'b11 && pr_match == 2'b00) |-> !pr_valid[victim]);

endmodule

// File: rtl/tlb2w.sv
module tlb2w
   import tlb2w_pkg::*;
#(
   parameter int VA_W   = 32,
   parameter int PAGE_W = 12,
   parameter int SETS   = 64,
   parameter int PID_W  = 8,
   parameter int PPN_W  = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              lk_req,
   input  logic [VA_W-1:0]   lk_vaddr,
   input  logic [PID_W-1:0]  lk_pid,
   input  logic              lk_user,
   output logic              lk_hit,
   output logic              lk_miss,
   output logic              lk_way,
   output logic [PPN_W-1:0]  lk_ppn,
   output logic [ATTR_W-1:0] lk_attr,
   output logic              lk_deny,
   input  logic              rf_req,
   input  logic [VA_W-1:0]   rf_vaddr,
   input  logic [PID_W-1:0]  rf_pid,
   input  logic [PPN_W-1:0]  rf_ppn,
   input  logic [ATTR_W-1:0] rf_attr
);

   localparam int IDX_W = $clog2(SETS);
   localparam int IDX_L = PAGE_W;
   localparam int TAG_L = PAGE_W + IDX_W;
   localparam int TAG_W = VA_W - TAG_L;
   localparam int WAYS  = 2;

   initial begin
      assert (SETS == (1 << IDX_W)) else $error("SETS must be a power of two");
      assert (TAG_W >= 2) else $error("address too narrow for page and index");
      assert (SETS >= 2) else $error("at least two sets required");
   end

   logic [IDX_W-1:0] lk_idx, rf_idx;
   logic [TAG_W-1:0] lk_tag, rf_tag;
   logic             lk_sys, rf_sys;
   logic             unused_offsets;

   assign lk_idx = lk_vaddr[TAG_L-1:IDX_L];
   assign rf_idx = rf_vaddr[TAG_L-1:IDX_L];
   assign lk_tag = lk_vaddr[VA_W-1:TAG_L];
   assign rf_tag = rf_vaddr[VA_W-1:TAG_L];
   assign lk_sys = lk_vaddr[VA_W-1];
   assign rf_sys = rf_vaddr[VA_W-1];
   assign unused_offsets = ^{lk_vaddr[PAGE_W-1:0], rf_vaddr[PAGE_W-1:0]};

   logic [WAYS-1:0]  way_hit, pr_match, pr_valid;
   logic [PPN_W-1:0] way_ppn  [WAYS];
   pte_attr_t        way_attr [WAYS];
   logic             victim;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic wr_en;
      assign wr_en = rf_req && !flush && (victim == 1'(w));
      tlb2w_way #(.SETS(SETS), .TAG_W(TAG_W), .PID_W(PID_W), .PPN_W(PPN_W)) u_way (
         .clk      (clk),
         .rst_n    (rst_n),
         .flush    (flush),
         .lk_idx   (lk_idx),
         .lk_tag   (lk_tag),
         .lk_pid   (lk_pid),
         .lk_sys   (lk_sys),
         .lk_match (way_hit[w]),
         .lk_ppn   (way_ppn[w]),
         .lk_attr  (way_attr[w]),
         .rf_idx   (rf_idx),
         .rf_tag   (rf_tag),
         .rf_pid   (rf_pid),
         .rf_sys   (rf_sys),
         .rf_ppn   (rf_ppn),
         .rf_attr  (pte_attr_t'(rf_attr)),
         .wr_en    (wr_en),
         .pr_match (pr_match[w]),
         .pr_valid (pr_valid[w])
      );
   end

   tlb2w_repl #(.SETS(SETS)) u_repl (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .rf_req   (rf_req),
      .rf_idx   (rf_idx),
      .pr_match (pr_match),
      .pr_valid (pr_valid),
      .victim   (victim)
   );

   pte_attr_t sel_attr;

   always_comb begin
      lk_hit   = lk_req && (|way_hit);
      lk_miss  = lk_req && !(|way_hit);
      lk_way   = lk_hit && way_hit[1];
      lk_ppn   = '0;
      sel_attr = '0;
      if (lk_hit) begin
         lk_ppn   = way_ppn[lk_way];
         sel_attr = way_attr[lk_way];
      end
      lk_attr = sel_attr;
      lk_deny = lk_hit && lk_user && sel_attr.sys_only;
   end

   // R9: duplicates are never stored, so two ways never match together
   assert_single_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(way_hit));

   // R5: no result is reported without a request
   assert_quiet_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_req |-> !(lk_hit || lk_miss || lk_deny));

   // R1: nothing hits in the cycle after a flush
   assert_no_hit_after_flush_R1: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !lk_hit);

endmodule

// File: tb/tb_tlb2w.sv
module tb_tlb2w;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        flush;
   logic        lk_req;
   logic [31:0] lk_vaddr;
   logic [7:0]  lk_pid;
   logic        lk_user;
   logic        lk_hit, lk_miss, lk_way, lk_deny;
   logic [19:0] lk_ppn;
   logic [3:0]  lk_attr;
   logic        rf_req;
   logic [31:0] rf_vaddr;
   logic [7:0]  rf_pid;
   logic [19:0] rf_ppn;
   logic [3:0]  rf_attr;

   always #10 clk = ~clk;

   tlb2w dut (.*);

   // behavioural reference state
   bit         mv   [2][64];
   bit [13:0]  mt   [2][64];
   bit [7:0]   mp   [2][64];
   bit [19:0]  mppn [2][64];
   bit [3:0]   ma   [2][64];
   bit         mfc  [64];

   int    checks = 0;
   int    fails  = 0;
   bit    done   = 0;
   string cur_req = "R1";

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic model_clear();
      for (int w = 0; w < 2; w++)
         for (int s = 0; s < 64; s++) mv[w][s] = 0;
      for (int s = 0; s < 64; s++) mfc[s] = 0;
   endtask

   function automatic bit mmatch(int w, int s, bit [13:0] t, bit [7:0] p);
      return mv[w][s] && mt[w][s] == t && (t[13] || mp[w][s] == p);
   endfunction

   // one clock: check outputs at the falling edge, then advance the model
   task automatic cyc();
      int  s;
      bit  eh;
      bit  ew;
      bit [19:0] eppn;
      bit [3:0]  eattr;
      @(negedge clk);
      s = int'(lk_vaddr[17:12]);
      eh = 0; ew = 0; eppn = 0; eattr = 0;
      for (int w = 0; w < 2; w++)
         if (lk_req && mmatch(w, s, lk_vaddr[31:18], lk_pid)) begin
            eh = 1; ew = w[0];
         end
      if (eh) begin
         eppn = mppn[ew][s]; eattr = ma[ew][s];
      end
      chk(cur_req, "lk_hit", 32'(lk_hit), 32'(eh));
      chk("R5", "lk_miss", 32'(lk_miss), 32'(lk_req && !eh));
      chk("R4", "lk_way", 32'(lk_way), 32'(ew));
      chk("R4", "lk_ppn", 32'(lk_ppn), 32'(eppn));
      chk("R4", "lk_attr", 32'(lk_attr), 32'(eattr));
      chk("R6", "lk_deny", 32'(lk_deny), 32'(eh && lk_user && eattr[2]));
      if (flush) begin
         model_clear();
      end else if (rf_req) begin
         int  rs;
         bit  m0, m1;
         int  vw;
         rs = int'(rf_vaddr[17:12]);
         m0 = mmatch(0, rs, rf_vaddr[31:18], rf_pid);
         m1 = mmatch(1, rs, rf_vaddr[31:18], rf_pid);
         if (m1)              vw = 1;
         else if (m0)         vw = 0;
         else if (!mv[0][rs]) vw = 0;
         else if (!mv[1][rs]) vw = 1;
         else                 vw = int'(mfc[rs]);
         if (!m0 && !m1) mfc[rs] = (vw == 0);
         mv[vw][rs]   = 1;
         mt[vw][rs]   = rf_vaddr[31:18];
         mp[vw][rs]   = rf_pid;
         mppn[vw][rs] = rf_ppn;
         ma[vw][rs]   = rf_attr;
      end
      @(posedge clk);
      #1;
   endtask

   task automatic idle();
      flush = 0; lk_req = 0; lk_vaddr = 0; lk_pid = 0; lk_user = 0;
      rf_req = 0; rf_vaddr = 0; rf_pid = 0; rf_ppn = 0; rf_attr = 0;
   endtask

   task automatic refill(bit [31:0] va, bit [7:0] pid, bit [19:0] ppn, bit [3:0] at);
      idle();
      rf_req = 1; rf_vaddr = va; rf_pid = pid; rf_ppn = ppn; rf_attr = at;
      cyc();
   endtask

   task automatic look(bit [31:0] va, bit [7:0] pid, bit user);
      idle();
      lk_req = 1; lk_vaddr = va; lk_pid = pid; lk_user = user;
      cyc();
   endtask

   function automatic bit [31:0] mkva(bit sys, bit [12:0] t, bit [5:0] s, bit [11:0] off);
      return {sys, t, s, off};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R10 watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      idle();
      rst_n = 0;
      model_clear();
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1;

      // R1: empty after reset
      cur_req = "R1";
      look(mkva(0, 13'h5, 6'd5, 12'h0), 8'd3, 0);
      look(mkva(1, 13'h0, 6'd0, 12'h0), 8'd0, 0);

      // R7 and R10: first fill of set 5, lookup in the same cycle misses
      cur_req = "R10";
      idle();
      rf_req = 1; rf_vaddr = mkva(0, 13'h5, 6'd5, 12'h0); rf_pid = 8'd3;
      rf_ppn = 20'hABCDE; rf_attr = 4'b1010;
      lk_req = 1; lk_vaddr = rf_vaddr; lk_pid = 8'd3;
      cyc();
      cur_req = "R7";
      look(mkva(0, 13'h5, 6'd5, 12'h123), 8'd3, 1);

      // R2: offset ignored, other set and other tag miss
      cur_req = "R2";
      look(mkva(0, 13'h5, 6'd5, 12'hFFF), 8'd3, 0);
      look(mkva(0, 13'h5, 6'd6, 12'h0), 8'd3, 0);
      look(mkva(0, 13'h6, 6'd5, 12'h0), 8'd3, 0);

      // R3: identifier matters in user space only
      cur_req = "R3";
      look(mkva(0, 13'h5, 6'd5, 12'h0), 8'd4, 0);
      refill(mkva(1, 13'h7, 6'd9, 12'h0), 8'd1, 20'h11111, 4'b0100);
      look(mkva(1, 13'h7, 6'd9, 12'h0), 8'd200, 0);

      // R6: user access to a system-only page is denied, kernel access not
      cur_req = "R6";
      look(mkva(1, 13'h7, 6'd9, 12'h0), 8'd5, 1);
      look(mkva(1, 13'h7, 6'd9, 12'h0), 8'd5, 0);

      // R7 then R8: fill set 5 to full, then new tags alternate
      cur_req = "R7";
      refill(mkva(0, 13'h8, 6'd5, 12'h0), 8'd3, 20'h22222, 4'b1000);
      look(mkva(0, 13'h8, 6'd5, 12'h0), 8'd3, 0);
      cur_req = "R8";
      refill(mkva(0, 13'h9, 6'd5, 12'h0), 8'd3, 20'h33333, 4'b0001);
      look(mkva(0, 13'h5, 6'd5, 12'h0), 8'd3, 0);
      look(mkva(0, 13'h9, 6'd5, 12'h0), 8'd3, 0);
      refill(mkva(0, 13'hA, 6'd5, 12'h0), 8'd3, 20'h44444, 4'b0011);
      look(mkva(0, 13'h8, 6'd5, 12'h0), 8'd3, 0);
      look(mkva(0, 13'hA, 6'd5, 12'h0), 8'd3, 0);

      // R9: same page again rewrites in place, first-come unchanged
      cur_req = "R9";
      refill(mkva(0, 13'hA, 6'd5, 12'h0), 8'd3, 20'h55555, 4'b1111);
      look(mkva(0, 13'hA, 6'd5, 12'h0), 8'd3, 1);
      look(mkva(0, 13'h9, 6'd5, 12'h0), 8'd3, 0);
      refill(mkva(0, 13'hB, 6'd5, 12'h0), 8'd3, 20'h66666, 4'b0000);
      look(mkva(0, 13'h9, 6'd5, 12'h0), 8'd3, 0);
      look(mkva(0, 13'hA, 6'd5, 12'h0), 8'd3, 0);

      // R1: flush, including a refill presented with it
      cur_req = "R1";
      idle();
      flush = 1; rf_req = 1; rf_vaddr = mkva(0, 13'hC, 6'd2, 12'h0); rf_pid = 8'd1;
      cyc();
      look(mkva(0, 13'hC, 6'd2, 12'h0), 8'd1, 0);
      look(mkva(0, 13'hA, 6'd5, 12'h0), 8'd3, 0);
      look(mkva(1, 13'h7, 6'd9, 12'h0), 8'd1, 0);

      // random stream over a narrow space
      cur_req = "R2";
      for (int i = 0; i < 4000; i++) begin
         bit [5:0] sets [3];
         sets[0] = 6'd0; sets[1] = 6'd1; sets[2] = 6'd63;
         idle();
         flush  = ($urandom_range(0, 199) == 0);
         lk_req = $urandom_range(0, 3) != 0;
         lk_vaddr = mkva(1'($urandom_range(0, 1)), 13'($urandom_range(0, 3)),
                         sets[$urandom_range(0, 2)], 12'($urandom));
         lk_pid  = 8'($urandom_range(1, 2));
         lk_user = 1'($urandom_range(0, 1));
         rf_req  = $urandom_range(0, 2) == 0;
         rf_vaddr = mkva(1'($urandom_range(0, 1)), 13'($urandom_range(0, 3)),
                         sets[$urandom_range(0, 2)], 12'($urandom));
         rf_pid  = 8'($urandom_range(1, 2));
         rf_ppn  = 20'($urandom);
         rf_attr = 4'($urandom);
         cyc();
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule